// File: doc/BRIEF.md
# Serial ADC Host Reader

This block sits on the host side of a serially controlled 8-bit analog-to-digital converter. A single start request makes it drop the select line, wait for the converter to notice the select, and toggle the I/O clock eight times. On each toggle it shifts one result bit into a register, most significant bit first. Each access also starts the converter's next conversion. For that reason the byte returned by any access is the result of the conversion begun by the access before it.

After the eighth falling clock edge the controller presents the byte with a one-cycle done pulse. It then stays busy for a conversion window, with the I/O clock held low, so that the next access cannot abort the conversion in progress. Every timing value is a parameter counted in host clock cycles. These are the half-period of the I/O clock, the select setup wait and the conversion wait. One parameter selects whether the select line is raised between accesses or kept low for good. Another parameter selects whether the first read after reset, which carries a stale value, is dropped.

Top module: `adc_serial_reader`

## Requirements
- R1: While reset is asserted and right after it, `cs_n` is 1, `sclk` is 0, `busy` is 0, `done` is 0 and `data` is 8'h00.
- R2: A `start` seen high at a rising clock edge while `busy` is 0 begins an access, and `busy` reads 1 from that edge onward. A `start` that arrives while `busy` is 1 has no effect on any output.
- R3: At the accepting edge `cs_n` goes to 0. The first rising edge of `sclk` comes SETUP_CYC cycles later. In keep-select mode, if `cs_n` is already 0, there is no setup wait and `sclk` rises at the accepting edge.
- R4: An access produces exactly eight `sclk` pulses. Each pulse is high for DIV_HALF cycles, with DIV_HALF low cycles between pulses.
- R5: The controller samples `sdo` at each edge where it drives `sclk` from 1 to 0, that is, before the converter shifts its next bit. The first sample becomes `data[7]` and the eighth becomes `data[0]`.
- R6: `done` is high for exactly one cycle. It starts at the edge of the eighth falling `sclk`, and `data` takes its new value at that same edge. At all other times `data` keeps its value.
- R7: After the eighth falling edge, `sclk` stays 0 and `busy` stays 1 for CONV_CYC further cycles. `busy` then returns to 0.
- R8: With KEEP_SEL=0, `cs_n` rises at the eighth falling edge and stays high until the next accepted start. With KEEP_SEL=1, `cs_n` stays 0 from the first accepted start onward.
- R9: With DROP_FIRST=1, the first access after reset gives no `done` pulse and leaves `data` unchanged. All later accesses report normally.
- R10: The byte reported by an access equals the value the converter produced for the conversion started by the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one read-and-convert access |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Converter I/O clock, idles low |
| busy | output | 1 | Access or conversion wait in progress |
| done | output | 1 | One-cycle pulse: `data` holds a new byte |
| data | output | 8 | Last captured byte |

## Verification
Take the edge that accepts a start as cycle 0, and let S be the setup wait (SETUP_CYC, or zero when the select line is already low). Counted from cycle 0, `sclk` rises at cycles S + 2·i·DIV_HALF and falls DIV_HALF cycles after each rise. `done` and the new `data` appear at cycle S + 15·DIV_HALF. `busy` clears at cycle S + 15·DIV_HALF + CONV_CYC. The reference model in the bench advances a phase counter from the accepting edge and derives every expected output from these formulas. It compares all outputs on the falling clock edge of every cycle, so each check samples after the registers have settled. Two instances, one in each select mode and drop setting, receive the same start stream.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DIV_HALF   = 4,
  parameter int SETUP_CYC  = 16,
  parameter int CONV_CYC   = 2400,
  parameter bit KEEP_SEL   = 1'b0,
  parameter bit DROP_FIRST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sdo,
  output logic       cs_n,
  output logic       sclk,
  output logic       busy,
  output logic       done,
  output logic [7:0] data
);
  localparam int MAX_A = (DIV_HALF > SETUP_CYC) ? DIV_HALF : SETUP_CYC;
  localparam int MAX_C = (MAX_A > CONV_CYC) ? MAX_A : CONV_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_LOW, S_WAIT} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [2:0]  nbit;
  logic [6:0]  sh;
  logic        skip;
  logic        cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '0;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      done <= 1'b0;
      data <= '0;
      skip <= DROP_FIRST;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          nbit <= '0;
          if (KEEP_SEL && !cs_n) begin
            st   <= S_HIGH;
            sclk <= 1'b1;
            cnt  <= CW'(DIV_HALF - 1);
          end else begin
            st   <= S_SETUP;
            cs_n <= 1'b0;
            cnt  <= CW'(SETUP_CYC - 1);
          end
        end
        S_SETUP: if (cnt_zero) begin
          st   <= S_HIGH;
          sclk <= 1'b1;
          cnt  <= CW'(DIV_HALF - 1);
        end else cnt <= cnt - 1'b1;
        S_HIGH: if (cnt_zero) begin
          sclk <= 1'b0;
          sh   <= {sh[5:0], sdo};
          nbit <= nbit + 1'b1;
          if (nbit == 3'd7) begin
            st  <= S_WAIT;
            cnt <= CW'(CONV_CYC - 1);
            if (!KEEP_SEL) cs_n <= 1'b1;
            if (skip) skip <= 1'b0;
            else begin
              done <= 1'b1;
              data <= {sh, sdo};
            end
          end else begin
            st  <= S_LOW;
            cnt <= CW'(DIV_HALF - 1);
          end
        end else cnt <= cnt - 1'b1;
        S_LOW: if (cnt_zero) begin
          st   <= S_HIGH;
          sclk <= 1'b1;
          cnt  <= CW'(DIV_HALF - 1);
        end else cnt <= cnt - 1'b1;
        S_WAIT: if (cnt_zero) st <= S_IDLE;
                else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic [7:0] data
);
  logic [3:0] rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rises <= '0;
    else if (!busy) rises <= '0;
    else if (sclk && !$past(sclk) && rises != 4'hF) rises <= rises + 1'b1;
  end

  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk);
  p_sclk_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> !cs_n);
  p_eight_pulses_r4: assert property (@(posedge clk) disable iff (!rst_n) rises <= 4'd8);
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(data));
  p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  p_sel_stays_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && $past(cs_n)) |-> cs_n);
endmodule

bind adc_serial_reader adc_serial_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .busy(busy), .done(done), .data(data)
);

// File: tb/tb_adc_serial_reader.sv
`timescale 1ns/1ps
module adc_ref #(
  parameter int DIV = 3, SETUP = 4, CONV = 20,
  parameter bit KEEP = 0, DROP = 1
) (
  input  logic       clk, rst_n, start,
  input  logic       cs_n, sclk, busy, done,
  input  logic [7:0] data,
  output logic       sdo
);
  localparam logic [7:0] PU = 8'hC3;
  int total = 0, bad = 0;
  int ph = -1, s = 0, k = 0, dk = 0, idx = 0;
  logic [7:0] prev = PU, cur = PU, e_data = 8'h00, held = PU;
  bit drop = DROP, cs_low = 0, dcs_q = 1, dsc_q = 0;
  logic e_cs, e_sclk, e_busy, e_done;

  function automatic logic [7:0] conv(int n);
    return 8'((n * 73 + 29) ^ (n * 8));
  endfunction

  task automatic cmp(string tag, string nm, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %m %s actual=%h expected=%h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  initial sdo = PU[7];

  always @(negedge clk) begin
    if (!rst_n) begin
      ph = -1; drop = DROP; e_data = 8'h00; cs_low = 0;
    end else begin
      if (ph >= 0) begin
        ph++;
        if (ph == s + 15*DIV + CONV) ph = -1;
      end else if (start) begin
        s = (KEEP && cs_low) ? 0 : SETUP;
        ph = 0; cur = prev; prev = conv(k); k++; cs_low = 1;
      end
      e_busy = (ph >= 0);
      e_sclk = (ph >= s) && (ph < s + 15*DIV) && (((ph - s) / DIV) % 2 == 0);
      e_cs   = KEEP ? !cs_low : !((ph >= 0) && (ph < s + 15*DIV));
      e_done = 0;
      if (ph == s + 15*DIV) begin
        if (drop) drop = 0;
        else begin e_done = 1; e_data = cur; end
      end
      cmp("R3 R8", "cs_n", {7'd0, cs_n}, {7'd0, e_cs});
      cmp("R4", "sclk", {7'd0, sclk}, {7'd0, e_sclk});
      cmp("R2 R7", "busy", {7'd0, busy}, {7'd0, e_busy});
      cmp("R6 R9", "done", {7'd0, done}, {7'd0, e_done});
      cmp("R5 R10", "data", data, e_data);
    end
    if (dcs_q && !cs_n) idx = 0;
    if (dsc_q && !sclk && !dcs_q) begin
      idx++;
      if (idx == 8) begin held = conv(dk); dk++; idx = 0; end
    end
    sdo = held[7 - idx];
    dcs_q = cs_n; dsc_q = sclk;
  end
endmodule

module tb_adc_serial_reader;
  logic clk = 0, rst_n = 0, start = 0;
  logic sdo0, sdo1;
  logic cs0, sc0, bz0, dn0, cs1, sc1, bz1, dn1;
  logic [7:0] d0, d1;
  int total = 0, bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  adc_serial_reader #(.DIV_HALF(3), .SETUP_CYC(4), .CONV_CYC(20), .KEEP_SEL(0), .DROP_FIRST(1)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo0),
    .cs_n(cs0), .sclk(sc0), .busy(bz0), .done(dn0), .data(d0));
  adc_ref #(.DIV(3), .SETUP(4), .CONV(20), .KEEP(0), .DROP(1)) r0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs0), .sclk(sc0),
    .busy(bz0), .done(dn0), .data(d0), .sdo(sdo0));

  adc_serial_reader #(.DIV_HALF(2), .SETUP_CYC(5), .CONV_CYC(9), .KEEP_SEL(1), .DROP_FIRST(0)) dut_keep (
    .clk(clk), .rst_n(rst_n), .start(start), .sdo(sdo1),
    .cs_n(cs1), .sclk(sc1), .busy(bz1), .done(dn1), .data(d1));
  adc_ref #(.DIV(2), .SETUP(5), .CONV(9), .KEEP(1), .DROP(0)) r1 (
    .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs1), .sclk(sc1),
    .busy(bz1), .done(dn1), .data(d1), .sdo(sdo1));

  task automatic chk_reset(logic c, logic s, logic b, logic d, logic [7:0] q);
    total++;
    if ({c, s, b, d, q} !== {1'b1, 1'b0, 1'b0, 1'b0, 8'h00}) begin
      bad++;
      $display("FAIL R1 reset outputs actual=%b expected=%b", {c, s, b, d, q}, 12'b100000000000);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total + r0.total + r1.total, bad + r0.bad + r1.bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset(cs0, sc0, bz0, dn0, d0);
    chk_reset(cs1, sc1, bz1, dn1, d1);
    #1 rst_n = 1;
    @(negedge clk);
    chk_reset(cs0, sc0, bz0, dn0, d0);
    chk_reset(cs1, sc1, bz1, dn1, d1);
    // R2: isolated pulses, waiting for idle
    for (int i = 0; i < 4; i++) begin
      #1 start = 1;
      @(negedge clk); #1 start = 0;
      while (bz0 || bz1) @(negedge clk);
      repeat (3) @(negedge clk);
    end
    // R7: start held high, back-to-back accesses
    #1 start = 1;
    repeat (600) @(negedge clk);
    #1 start = 0;
    // R2: pseudo-random requests, many while busy
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1 start = (lfsr[2:0] < 3'd2);
    end
    #1 start = 0;
    repeat (80) @(negedge clk);
    finish_run();
  end
endmodule